// File: doc/BRIEF.md
# Capture Event Interrupt Aggregator

The block gathers one-cycle event pulses from a video capture pipeline into two sticky 32-bit status words. Each status bit is masked into a single level interrupt. Each word has its own clear-select register. A global clear command applies both clear selects in one step, so software can acknowledge a chosen set of sources atomically.

It also tracks completion groups. A composite-select register assigns a subset of the write masters to each group. The group's composite-done status bit sets once every selected master has reported buffer done since that group last fired. Per-master done bits and per-group composite bits are reported side by side.

Software reaches the registers through a simple port. Writes take one cycle. Reads are combinational.

Top module: `cap_irq_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Status word 0 bit positions:
  - bit 0 is frame start and bit 1 is frame end.
  - bit 4 is pixel-path update done and bit 5+n is raw path n update done.
  - bit 8+n is write master n done and bit 25+g is composite group g done.
  - bit 31 is reset acknowledge.
  - The bit reads 1 from the clock edge after the pulse.
- R3: Status word 1 bit positions:
  - bit 0 is capture-interface error, bit 7 is violation and bit 8 is bus halt acknowledge.
  - bit 9+n is write master n overflow.
  - bit 29+n is raw path n frame start.
- R4: A set status bit stays set. A command write with bit 0 low, and writes to the status addresses (6 and 7), change nothing.
- R5: A command write (address 5) with bit 0 high clears exactly the status bits whose clear-select bit is 1, in both words. The clear-select registers keep their values.
- R6: An event arriving on the same edge as a global clear of its bit leaves that bit set.
- R7: `irq` is high exactly when some status bit of either word is 1 and its mask bit is 1.
- R8: Composite-select bit 8g+n puts master n into group g. The group's status bit sets on the edge that delivers the last outstanding done among its selected masters. Dones may arrive in any order or together, and one master may belong to several groups.
- R9: After a group fires, its tracking restarts. A fresh done from every selected master is needed before it fires again.
- R10: A group with an empty selection never fires. Writing the composite-select register discards partial progress in all groups.
- R11: Register map:
  - addresses 0/1 are mask 0/1, 2/3 are clear-select 0/1 and 4 is composite-select; all five read back what was written.
  - address 5 is the command register and reads zero.
  - addresses 6/7 read status 0/1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Write address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 3 | Read address |
| reg_rd_data | output | 32 | Read data (combinational) |
| ev_frame_start | input | 1 | Frame start pulse |
| ev_frame_end | input | 1 | Frame end pulse |
| ev_pix_upd_done | input | 1 | Pixel-path update done pulse |
| ev_raw_upd_done | input | NUM_RAW | Raw path update done pulses |
| ev_reset_ack | input | 1 | Reset acknowledge pulse |
| ev_wm_done | input | NUM_WM | Write master buffer done pulses |
| ev_capif_err | input | 1 | Capture-interface error pulse |
| ev_violation | input | 1 | Violation pulse |
| ev_halt_ack | input | 1 | Bus halt acknowledge pulse |
| ev_wm_overflow | input | NUM_WM | Write master overflow pulses |
| ev_raw_frame_start | input | NUM_RAW | Raw path frame start pulses |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are inside the composite trackers. A group can hold partial progress that shows on no register. The only sign of it is whether a later done makes the group fire.

The stimulus steers these states explicitly:
- For every group it sweeps several master selections and delivers dones one master at a time. The group bit must stay clear until the last selected master reports.
- It repeats one master's done after a fire, to show that tracking restarted.
- It rewrites the selection halfway through a group, to show that progress is discarded.
- It overlaps two groups on one master, so that a single done completes both.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
   localparam int unsigned DW        = 32;
   localparam int unsigned AW        = 3;
   localparam int unsigned GRP_FIELD = 8;

   typedef enum logic [AW-1:0] {
      A_MASK0 = 3'd0,
      A_MASK1 = 3'd1,
      A_CLR0  = 3'd2,
      A_CLR1  = 3'd3,
      A_COMP  = 3'd4,
      A_CMD   = 3'd5,
      A_STAT0 = 3'd6,
      A_STAT1 = 3'd7
   } reg_addr_e;

   // word 0 positions
   localparam int unsigned W0_SOF    = 0;
   localparam int unsigned W0_EOF    = 1;
   localparam int unsigned W0_PIXUPD = 4;
   localparam int unsigned W0_RAWUPD = 5;
   localparam int unsigned W0_WMDONE = 8;
   localparam int unsigned W0_COMP   = 25;
   localparam int unsigned W0_RSTACK = 31;
   // word 1 positions
   localparam int unsigned W1_CAPERR = 0;
   localparam int unsigned W1_VIOL   = 7;
   localparam int unsigned W1_HALT   = 8;
   localparam int unsigned W1_OVF    = 9;
   localparam int unsigned W1_RAWSOF = 29;
endpackage

// File: rtl/cirq_regs.sv
module cirq_regs
   import cirq_pkg::*;
#(
   parameter int unsigned NUM_WM  = 8,
   parameter int unsigned NUM_GRP = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [DW-1:0]             wr_data,
   input  logic [AW-1:0]             rd_addr,
   input  logic [DW-1:0]             stat0_i,
   input  logic [DW-1:0]             stat1_i,
   output logic [DW-1:0]             rd_data,
   output logic [DW-1:0]             mask0_o,
   output logic [DW-1:0]             mask1_o,
   output logic [DW-1:0]             clr0_o,
   output logic [DW-1:0]             clr1_o,
   output logic [NUM_GRP*NUM_WM-1:0] comp_sel_o,
   output logic                      gclr_o,
   output logic                      comp_wr_o
);
   logic [DW-1:0] comp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask0_o <= '0;
         mask1_o <= '0;
         clr0_o  <= '0;
         clr1_o  <= '0;
         comp_q  <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(wr_addr))
            A_MASK0: mask0_o <= wr_data;
            A_MASK1: mask1_o <= wr_data;
            A_CLR0:  clr0_o  <= wr_data;
            A_CLR1:  clr1_o  <= wr_data;
            A_COMP:  comp_q  <= wr_data;
            default: ;
         endcase
      end
   end

   assign gclr_o    = wr_en && (reg_addr_e'(wr_addr) == A_CMD) && wr_data[0];
   assign comp_wr_o = wr_en && (reg_addr_e'(wr_addr) == A_COMP);

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
      assign comp_sel_o[g*NUM_WM +: NUM_WM] = comp_q[g*GRP_FIELD +: NUM_WM];
   end

   always_comb begin
      case (reg_addr_e'(rd_addr))
         A_MASK0: rd_data = mask0_o;
         A_MASK1: rd_data = mask1_o;
         A_CLR0:  rd_data = clr0_o;
         A_CLR1:  rd_data = clr1_o;
         A_COMP:  rd_data = comp_q;
         A_STAT0: rd_data = stat0_i;
         A_STAT1: rd_data = stat1_i;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/cirq_word.sv
module cirq_word #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_go_i,
   input  logic [W-1:0] clr_sel_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] stat_o,
   output logic         hit_o
);
   // set takes priority over a clear landing on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= (stat_o & ~(clr_sel_i & {W{clr_go_i}})) | set_i;
   end

   assign hit_o = |(stat_o & mask_i);
endmodule

// File: rtl/cirq_comp_grp.sv
module cirq_comp_grp #(
   parameter int unsigned NUM_WM = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_WM-1:0] sel_i,
   input  logic [NUM_WM-1:0] done_i,
   input  logic              flush_i,
   output logic              fire_o
);
   logic [NUM_WM-1:0] seen_q;
   logic [NUM_WM-1:0] seen_all;

   assign seen_all = seen_q | done_i;
   assign fire_o   = (|sel_i) && ((seen_all & sel_i) == sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 seen_q <= '0;
      else if (flush_i || fire_o) seen_q <= '0;
      else                        seen_q <= seen_all & sel_i;
   end
endmodule

// File: rtl/cap_irq_aggregator.sv
module cap_irq_aggregator
   import cirq_pkg::*;
#(
   parameter int unsigned NUM_WM  = 8,
   parameter int unsigned NUM_GRP = 4,
   parameter int unsigned NUM_RAW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic [2:0]         reg_wr_addr,
   input  logic [31:0]        reg_wr_data,
   input  logic [2:0]         reg_rd_addr,
   output logic [31:0]        reg_rd_data,
   input  logic               ev_frame_start,
   input  logic               ev_frame_end,
   input  logic               ev_pix_upd_done,
   input  logic [NUM_RAW-1:0] ev_raw_upd_done,
   input  logic               ev_reset_ack,
   input  logic [NUM_WM-1:0]  ev_wm_done,
   input  logic               ev_capif_err,
   input  logic               ev_violation,
   input  logic               ev_halt_ack,
   input  logic [NUM_WM-1:0]  ev_wm_overflow,
   input  logic [NUM_RAW-1:0] ev_raw_frame_start,
   output logic               irq
);
   localparam int unsigned SELW = NUM_GRP * NUM_WM;

   // elaboration-time range checks
   if (NUM_WM < 1 || NUM_WM > GRP_FIELD) begin : g_bad_wm
      $error("NUM_WM must be 1..8");
   end
   if (NUM_GRP < 1 || NUM_GRP > DW / GRP_FIELD) begin : g_bad_grp
      $error("NUM_GRP must be 1..4");
   end
   if (NUM_RAW < 1 || NUM_RAW > 3) begin : g_bad_raw
      $error("NUM_RAW must be 1..3");
   end

   logic [DW-1:0]      mask0, mask1, clr0, clr1, stat0, stat1, set0, set1;
   logic [SELW-1:0]    comp_sel;
   logic [NUM_GRP-1:0] fire;
   logic               gclr, comp_wr, hit0, hit1;

   cirq_regs #(.NUM_WM(NUM_WM), .NUM_GRP(NUM_GRP)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .stat0_i(stat0), .stat1_i(stat1),
      .rd_data(reg_rd_data),
      .mask0_o(mask0), .mask1_o(mask1), .clr0_o(clr0), .clr1_o(clr1),
      .comp_sel_o(comp_sel), .gclr_o(gclr), .comp_wr_o(comp_wr)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      cirq_comp_grp #(.NUM_WM(NUM_WM)) u_grp (
         .clk(clk), .rst_n(rst_n),
         .sel_i(comp_sel[g*NUM_WM +: NUM_WM]),
         .done_i(ev_wm_done),
         .flush_i(comp_wr),
         .fire_o(fire[g])
      );
   end

   always_comb begin
      set0 = '0;
      set1 = '0;
      set0[W0_SOF]    = ev_frame_start;
      set0[W0_EOF]    = ev_frame_end;
      set0[W0_PIXUPD] = ev_pix_upd_done;
      set0[W0_RSTACK] = ev_reset_ack;
      set1[W1_CAPERR] = ev_capif_err;
      set1[W1_VIOL]   = ev_violation;
      set1[W1_HALT]   = ev_halt_ack;
      for (int n = 0; n < int'(NUM_RAW); n++) begin
         set0[W0_RAWUPD + n] = ev_raw_upd_done[n];
         set1[W1_RAWSOF + n] = ev_raw_frame_start[n];
      end
      for (int n = 0; n < int'(NUM_WM); n++) begin
         set0[W0_WMDONE + n] = ev_wm_done[n];
         set1[W1_OVF + n]    = ev_wm_overflow[n];
      end
      for (int g = 0; g < int'(NUM_GRP); g++) begin
         set0[W0_COMP + g] = fire[g];
      end
   end

   cirq_word #(.W(DW)) u_word0 (
      .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_go_i(gclr),
      .clr_sel_i(clr0), .mask_i(mask0), .stat_o(stat0), .hit_o(hit0)
   );

   cirq_word #(.W(DW)) u_word1 (
      .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_go_i(gclr),
      .clr_sel_i(clr1), .mask_i(mask1), .stat_o(stat1), .hit_o(hit1)
   );

   assign irq = hit0 | hit1;
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker #(
   parameter int unsigned NUM_WM  = 8,
   parameter int unsigned NUM_GRP = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ev_sof,
   input logic                      irq,
   input logic [31:0]               stat0,
   input logic [31:0]               stat1,
   input logic [31:0]               mask0,
   input logic [31:0]               mask1,
   input logic [31:0]               clr0,
   input logic [31:0]               set0,
   input logic                      gclr,
   input logic [NUM_GRP*NUM_WM-1:0] comp_sel,
   input logic [NUM_GRP-1:0]        fire
);
   assert_sof_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sof |=> stat0[0]) else $error("R2 frame start did not set bit 0");

   assert_sticky0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !gclr |=> ((stat0 & $past(stat0)) == $past(stat0)))
      else $error("R4 word 0 bit dropped without clear");

   assert_sticky1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !gclr |=> ((stat1 & $past(stat1)) == $past(stat1)))
      else $error("R4 word 1 bit dropped without clear");

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gclr && ((set0 & clr0) == '0)) |=> ((stat0 & $past(clr0)) == '0))
      else $error("R5 selected bits survived clear");

   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gclr && ev_sof) |=> stat0[0]) else $error("R6 clear beat event");

   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask0 == '0) && (mask1 == '0)) |-> !irq)
      else $error("R7 irq with all masks clear");

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assert_comp_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
         fire[g] |=> stat0[25+g]) else $error("R8 composite bit not set");
      assert_comp_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
         fire[g] |-> (comp_sel[g*NUM_WM +: NUM_WM] != '0))
         else $error("R10 empty group fired");
   end
endmodule

bind cap_irq_aggregator cirq_checker #(.NUM_WM(NUM_WM), .NUM_GRP(NUM_GRP)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_sof(ev_frame_start), .irq(irq),
   .stat0(stat0), .stat1(stat1), .mask0(mask0), .mask1(mask1),
   .clr0(clr0), .set0(set0), .gclr(gclr), .comp_sel(comp_sel), .fire(fire)
);

// File: tb/sim_cap_irq_aggregator.sv
`timescale 1ns/1ps
module sim_cap_irq_aggregator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [2:0]  reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        ev_frame_start = 0, ev_frame_end = 0, ev_pix_upd_done = 0, ev_reset_ack = 0;
   logic [2:0]  ev_raw_upd_done = '0, ev_raw_frame_start = '0;
   logic [7:0]  ev_wm_done = '0, ev_wm_overflow = '0;
   logic        ev_capif_err = 0, ev_violation = 0, ev_halt_ack = 0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cap_irq_aggregator u0 (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_rd_addr = a;
      #0.1;
      d = reg_rd_data;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   // source index k: 0 sof,1 eof,2 pixupd,3..5 rawupd,6..13 wmdone,14 rstack,
   // 15 caperr,16 viol,17 halt,18..25 ovf,26..28 rawsof
   task automatic pulse(input logic [28:0] s, input bit cmd);
      @(negedge clk);
      ev_frame_start = s[0]; ev_frame_end = s[1]; ev_pix_upd_done = s[2];
      ev_raw_upd_done = s[5:3]; ev_wm_done = s[13:6]; ev_reset_ack = s[14];
      ev_capif_err = s[15]; ev_violation = s[16]; ev_halt_ack = s[17];
      ev_wm_overflow = s[25:18]; ev_raw_frame_start = s[28:26];
      if (cmd) begin reg_wr_en = 1'b1; reg_wr_addr = 3'd5; reg_wr_data = 32'd1; end
      @(negedge clk);
      ev_frame_start = 0; ev_frame_end = 0; ev_pix_upd_done = 0; ev_raw_upd_done = '0;
      ev_wm_done = '0; ev_reset_ack = 0; ev_capif_err = 0; ev_violation = 0;
      ev_halt_ack = 0; ev_wm_overflow = '0; ev_raw_frame_start = '0;
      reg_wr_en = 1'b0;
   endtask

   function automatic logic [63:0] exp_of(input int k);
      int b;
      if (k == 0)       b = 0;
      else if (k == 1)  b = 1;
      else if (k == 2)  b = 4;
      else if (k <= 5)  b = 5 + k - 3;
      else if (k <= 13) b = 8 + k - 6;
      else if (k == 14) b = 31;
      else if (k == 15) b = 32;
      else if (k == 16) b = 32 + 7;
      else if (k == 17) b = 32 + 8;
      else if (k <= 25) b = 32 + 9 + k - 18;
      else              b = 32 + 29 + k - 26;
      return 64'd1 << b;
   endfunction

   function automatic logic [28:0] wm_src(input logic [7:0] m);
      return {15'd0, m, 6'd0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d0, d1;
      logic [7:0] masks [5];
      masks[0] = 8'h01; masks[1] = 8'h81; masks[2] = 8'h5A; masks[3] = 8'hFF; masks[4] = 8'h24;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d0);
         chk("R1 reset register", {32'd0, d0}, 64'd0);
      end
      chk("R1 irq after reset", {63'd0, irq}, 64'd0);

      // R11 readback
      wr(3'd0, 32'hA5A5_0F0F); wr(3'd1, 32'h1234_5678); wr(3'd2, 32'hDEAD_BEEF);
      wr(3'd3, 32'h0BAD_F00D); wr(3'd4, 32'hC3C3_3C3C);
      rd(3'd0, d0); chk("R11 mask0", {32'd0, d0}, {32'd0, 32'hA5A5_0F0F});
      rd(3'd1, d0); chk("R11 mask1", {32'd0, d0}, {32'd0, 32'h1234_5678});
      rd(3'd2, d0); chk("R11 clr0", {32'd0, d0}, {32'd0, 32'hDEAD_BEEF});
      rd(3'd3, d0); chk("R11 clr1", {32'd0, d0}, {32'd0, 32'h0BAD_F00D});
      rd(3'd4, d0); chk("R11 comp", {32'd0, d0}, {32'd0, 32'hC3C3_3C3C});
      rd(3'd5, d0); chk("R11 cmd reads zero", {32'd0, d0}, 64'd0);
      wr(3'd0, 0); wr(3'd1, 0); wr(3'd4, 0);
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      pulse(29'd0, 1'b1);

      // R2/R3/R7/R5 sweep over every source
      for (int k = 0; k < 29; k++) begin
         logic [63:0] e;
         logic [2:0] ma;
         logic [31:0] mb;
         e = exp_of(k);
         ma = (k < 15) ? 3'd0 : 3'd1;
         mb = (k < 15) ? e[31:0] : e[63:32];
         pulse(29'd1 << k, 1'b0);
         rd(3'd6, d0); rd(3'd7, d1);
         chk((k < 15) ? "R2 word0 placement" : "R3 word1 placement", {d1, d0}, e);
         chk("R7 irq masked off", {63'd0, irq}, 64'd0);
         wr(ma, mb);
         #0.1 chk("R7 irq with mask", {63'd0, irq}, 64'd1);
         wr(ma, ~mb);
         #0.1 chk("R7 irq other bits masked", {63'd0, irq}, 64'd0);
         wr(ma, 0);
         pulse(29'd0, 1'b1);
         rd(3'd6, d0); rd(3'd7, d1);
         chk("R5 full clear", {d1, d0}, 64'd0);
      end

      // R4 sticky and ignored writes
      pulse(29'd1 | (29'd1 << 18), 1'b0);
      wr(3'd5, 32'hFFFF_FFFE);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'd0);
      rd(3'd6, d0); rd(3'd7, d1);
      chk("R4 sticky word0", {32'd0, d0}, 64'd1);
      chk("R4 sticky word1", {32'd0, d1}, {32'd0, 32'd1 << 9});

      // R5 selective clear
      wr(3'd2, 32'd1); wr(3'd3, 32'd0);
      pulse(29'd0, 1'b1);
      rd(3'd6, d0); rd(3'd7, d1);
      chk("R5 selected cleared", {32'd0, d0}, 64'd0);
      chk("R5 unselected kept", {32'd0, d1}, {32'd0, 32'd1 << 9});
      rd(3'd2, d0);
      chk("R5 clear select retained", {32'd0, d0}, 64'd1);

      // R6 event wins over clear
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      pulse(29'd2, 1'b0);
      pulse(29'd1, 1'b1);
      rd(3'd6, d0); rd(3'd7, d1);
      chk("R6 event wins, others cleared", {d1, d0}, 64'd1);
      pulse(29'd0, 1'b1);

      // R8/R9 composite sweep
      for (int g = 0; g < 4; g++) begin
         for (int mi = 0; mi < 5; mi++) begin
            logic [7:0] m;
            int remain, first;
            m = masks[mi];
            remain = $countones(m);
            first = -1;
            wr(3'd4, 32'(m) << (8 * g));
            pulse(29'd0, 1'b1);
            for (int n = 0; n < 8; n++) begin
               if (m[n]) begin
                  if (first < 0) first = n;
                  pulse(wm_src(8'd1 << n), 1'b0);
                  remain--;
                  rd(3'd6, d0);
                  chk("R8 composite fires on last master",
                      {60'd0, d0[28:25]}, (remain == 0) ? (64'd1 << g) : 64'd0);
               end
            end
            pulse(29'd0, 1'b1);
            pulse(wm_src(8'd1 << first), 1'b0);
            rd(3'd6, d0);
            chk("R9 tracking restarts after fire", {60'd0, d0[28:25]},
                ($countones(m) == 1) ? (64'd1 << g) : 64'd0);
            pulse(29'd0, 1'b1);
            pulse(wm_src(m), 1'b0);
            rd(3'd6, d0);
            chk("R8 simultaneous dones", {60'd0, d0[28:25]}, 64'd1 << g);
            pulse(29'd0, 1'b1);
         end
      end

      // R10 empty group and flush on select write
      wr(3'd4, 32'd0);
      pulse(wm_src(8'hFF), 1'b0);
      rd(3'd6, d0);
      chk("R10 empty group silent", {60'd0, d0[28:25]}, 64'd0);
      pulse(29'd0, 1'b1);
      wr(3'd4, 32'h03);
      pulse(wm_src(8'h01), 1'b0);
      wr(3'd4, 32'h03);
      pulse(wm_src(8'h02), 1'b0);
      rd(3'd6, d0);
      chk("R10 select write discards progress", {60'd0, d0[28:25]}, 64'd0);
      pulse(wm_src(8'h01), 1'b0);
      rd(3'd6, d0);
      chk("R10 completes after fresh dones", {60'd0, d0[28:25]}, 64'd1);
      pulse(29'd0, 1'b1);

      // R8 shared master across two groups
      wr(3'd4, 32'h0000_0301);
      pulse(wm_src(8'h02), 1'b0);
      rd(3'd6, d0);
      chk("R8 shared partial", {60'd0, d0[28:25]}, 64'd0);
      pulse(wm_src(8'h01), 1'b0);
      rd(3'd6, d0);
      chk("R8 shared master completes both", {60'd0, d0[28:25]}, 64'd3);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule